// File: doc/BRIEF.md
# Multi-Issue Register Scoreboard

This block keeps one pending bit per architectural register for a core that dispatches a group of up to `LANES` instructions each cycle. A set bit means an instruction has been issued that will write that register, and its result has not yet come back. Each lane of the dispatch group offers two source indices, a destination index, a write flag and a valid flag. In the same cycle the block answers, lane by lane, whether that instruction may issue.

An instruction is held back when it reads a register whose write is still outstanding, or whose destination is already outstanding. It is also held back when it collides with an older lane of its own group, either by reading that lane's destination or by writing the same destination. Issue is strictly in order. Lane 0 is the oldest, and a held lane holds every younger lane behind it. When an instruction issues and writes a register, the bit for that register is set on the next clock edge. Up to `WB_PORTS` writeback ports clear bits on the same edge. If a set and a clear hit the same register, the set wins. Register 0 is hardwired and is never tracked.

The parameter `CLR_ORDER` chooses whether a clear arriving in the current cycle already counts for the current dispatch search. `CLR_BEFORE_SEARCH` suits a register file that forwards its write data to same-cycle reads. `CLR_AFTER_SEARCH` suits one that does not.

Top module: `issue_scoreboard`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves every bit of `pending_flags` at 0 after that edge.
- R2: A valid lane does not issue when either of its nonzero source indices has its pending bit set in the visible table.
- R3: A valid lane does not issue when one of its sources equals the nonzero destination of an older valid lane in the same group that has its write flag set.
- R4: A valid lane with its write flag set does not issue when its destination equals the nonzero destination of an older valid writing lane in the same group.
- R5: A valid lane with its write flag set does not issue when its nonzero destination is already pending in the visible table.
- R6: Issue is in order. `issue_ok[i]` is 1 only if lane i is valid, free of hazards, and no older valid lane was held. An invalid lane never issues and never holds younger lanes.
- R7: Index 0 never becomes pending, and a source or destination of 0 never causes a hold.
- R8: One cycle after a lane issues with its write flag set and a nonzero destination, that destination's bit in `pending_flags` is 1. Held and invalid lanes set nothing.
- R9: One cycle after writeback port k has `wb_en[k]` high with a nonzero index, that register's bit is 0, unless an issuing lane inserts the same register in the same cycle.
- R10: When an insert and a writeback clear name the same register in one cycle, the bit is 1 afterwards.
- R11: With `CLR_ORDER = CLR_BEFORE_SEARCH`, a register being cleared in the current cycle does not hold any lane (visible table = flags with current clears removed). With `CLR_AFTER_SEARCH`, the search sees the flags as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cand_valid | input | LANES | Lane i holds an instruction |
| cand_src_a | input | LANES*IDXW | First source index, lane i at bits [i*IDXW +: IDXW] |
| cand_src_b | input | LANES*IDXW | Second source index, same packing |
| cand_dst | input | LANES*IDXW | Destination index, same packing |
| cand_wen | input | LANES | Lane i writes its destination |
| issue_ok | output | LANES | Lane i may issue this cycle (combinational) |
| wb_en | input | WB_PORTS | Writeback port k completes a write |
| wb_idx | input | WB_PORTS*IDXW | Register written by port k, same packing |
| pending_flags | output | NREGS | Stored pending bit per register |

## Verification
`issue_ok` is combinational from the inputs and the stored flags. The bench therefore drives each group on a falling edge and samples `issue_ok` one time unit later, before the next rising edge. `pending_flags` changes only on the rising edge that follows, so the bench checks the updated flags one time unit after that edge, against its own model advanced by exactly one step. Two instances, one for each clear ordering, receive identical stimulus. Each is compared with a model that uses its own ordering, so any same-cycle clear that lands on a searched register exposes the difference.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    CLR_AFTER_SEARCH  = 1'b0,
    CLR_BEFORE_SEARCH = 1'b1
  } clr_order_e;
endpackage

// File: rtl/sb_onehot_or.sv
module sb_onehot_or #(
  parameter int PORTS = 2,
  parameter int NREGS = 32,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic [PORTS-1:0]      en,
  input  logic [PORTS*IDXW-1:0] idx,
  output logic [NREGS-1:0]      mask
);
  always_comb begin
    mask = '0;
    for (int k = 0; k < PORTS; k++) begin
      if (en[k]) mask[idx[k*IDXW +: IDXW]] = 1'b1;
    end
    mask[0] = 1'b0;
  end
endmodule

// File: rtl/sb_table.sv
module sb_table #(
  parameter int NREGS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREGS-1:0] set_mask,
  input  logic [NREGS-1:0] clr_mask,
  output logic [NREGS-1:0] flags
);
  function automatic logic [NREGS-1:0] next_flags(
    input logic [NREGS-1:0] cur, input logic [NREGS-1:0] s, input logic [NREGS-1:0] c);
    logic [NREGS-1:0] n;
    n = (cur & ~c) | s;
    n[0] = 1'b0;
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= next_flags(flags, set_mask, clr_mask);
  end
endmodule

// File: rtl/sb_table_probe.sv
module sb_table_probe #(
  parameter int NREGS = 32,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] vis,
  input  logic [IDXW-1:0]  src_a,
  input  logic [IDXW-1:0]  src_b,
  input  logic [IDXW-1:0]  dst,
  input  logic             wen,
  output logic             hit
);
  function automatic logic busy(input logic [NREGS-1:0] v, input logic [IDXW-1:0] r);
    return (r != '0) && v[r];
  endfunction

  assign hit = busy(vis, src_a) || busy(vis, src_b) || (wen && busy(vis, dst));
endmodule

// File: rtl/sb_pair_check.sv
module sb_pair_check #(
  parameter int IDXW = 5
) (
  input  logic            old_valid,
  input  logic            old_wen,
  input  logic [IDXW-1:0] old_dst,
  input  logic [IDXW-1:0] yng_src_a,
  input  logic [IDXW-1:0] yng_src_b,
  input  logic [IDXW-1:0] yng_dst,
  input  logic            yng_wen,
  output logic            hit
);
  logic old_writes;
  assign old_writes = old_valid && old_wen && (old_dst != '0);
  assign hit = old_writes &&
               ((yng_src_a == old_dst) || (yng_src_b == old_dst) ||
                (yng_wen && (yng_dst == old_dst)));
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int         LANES     = 2,
  parameter int         WB_PORTS  = 2,
  parameter int         NREGS     = 32,
  parameter clr_order_e CLR_ORDER = CLR_BEFORE_SEARCH,
  localparam int        IDXW      = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         cand_valid,
  input  logic [LANES*IDXW-1:0]    cand_src_a,
  input  logic [LANES*IDXW-1:0]    cand_src_b,
  input  logic [LANES*IDXW-1:0]    cand_dst,
  input  logic [LANES-1:0]         cand_wen,
  output logic [LANES-1:0]         issue_ok,
  input  logic [WB_PORTS-1:0]      wb_en,
  input  logic [WB_PORTS*IDXW-1:0] wb_idx,
  output logic [NREGS-1:0]         pending_flags
);
  logic [NREGS-1:0]            set_mask;
  logic [NREGS-1:0]            clr_mask;
  logic [NREGS-1:0]            vis_pend;
  logic [LANES-1:0]            tbl_hit;
  logic [LANES-1:0]            grp_hit;
  logic [LANES-1:0]            lane_hazard;
  logic [LANES-1:0]            ins_en;
  logic [LANES-1:0][LANES-1:0] pair_hit;

  sb_onehot_or #(.PORTS(WB_PORTS), .NREGS(NREGS), .IDXW(IDXW)) u_clr (
    .en(wb_en), .idx(wb_idx), .mask(clr_mask));

  generate
    if (CLR_ORDER == CLR_BEFORE_SEARCH) begin : g_early
      assign vis_pend = pending_flags & ~clr_mask;
    end else begin : g_late
      assign vis_pend = pending_flags;
    end
  endgenerate

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sb_table_probe #(.NREGS(NREGS), .IDXW(IDXW)) u_probe (
      .vis(vis_pend),
      .src_a(cand_src_a[i*IDXW +: IDXW]),
      .src_b(cand_src_b[i*IDXW +: IDXW]),
      .dst(cand_dst[i*IDXW +: IDXW]),
      .wen(cand_wen[i]),
      .hit(tbl_hit[i]));
    for (genvar j = 0; j < LANES; j++) begin : g_old
      if (j < i) begin : g_cmp
        sb_pair_check #(.IDXW(IDXW)) u_pair (
          .old_valid(cand_valid[j]),
          .old_wen(cand_wen[j]),
          .old_dst(cand_dst[j*IDXW +: IDXW]),
          .yng_src_a(cand_src_a[i*IDXW +: IDXW]),
          .yng_src_b(cand_src_b[i*IDXW +: IDXW]),
          .yng_dst(cand_dst[i*IDXW +: IDXW]),
          .yng_wen(cand_wen[i]),
          .hit(pair_hit[i][j]));
      end else begin : g_none
        assign pair_hit[i][j] = 1'b0;
      end
    end
    assign grp_hit[i]     = |pair_hit[i];
    assign lane_hazard[i] = tbl_hit[i] | grp_hit[i];
  end

  always_comb begin
    logic held;
    held = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      issue_ok[i] = cand_valid[i] & ~lane_hazard[i] & ~held;
      held        = held | (cand_valid[i] & lane_hazard[i]);
    end
  end

  assign ins_en = issue_ok & cand_wen;

  sb_onehot_or #(.PORTS(LANES), .NREGS(NREGS), .IDXW(IDXW)) u_set (
    .en(ins_en), .idx(cand_dst), .mask(set_mask));

  sb_table #(.NREGS(NREGS)) u_table (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
    .flags(pending_flags));
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int LANES = 2,
  parameter int NREGS = 32,
  parameter int IDXW  = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LANES-1:0]      cand_valid,
  input logic [LANES*IDXW-1:0] cand_src_a,
  input logic [LANES*IDXW-1:0] cand_src_b,
  input logic [LANES-1:0]      issue_ok,
  input logic [NREGS-1:0]      set_mask,
  input logic [NREGS-1:0]      clr_mask,
  input logic [NREGS-1:0]      vis_pend,
  input logic [NREGS-1:0]      pending_flags
);
  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (pending_flags == '0)); // R1

  AST_ZERO_UNTRACKED: assert property (@(posedge clk) disable iff (rst)
    !pending_flags[0]); // R7

  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((pending_flags & $past(set_mask)) == $past(set_mask))); // R8

  AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_mask & ~set_mask)) |=> ((pending_flags & $past(clr_mask & ~set_mask)) == '0)); // R9

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    AST_ISSUE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      issue_ok[i] |-> cand_valid[i]); // R6

    AST_ISSUE_SRC_FREE: assert property (@(posedge clk) disable iff (rst)
      issue_ok[i] |-> !((cand_src_a[i*IDXW +: IDXW] != '0 && vis_pend[cand_src_a[i*IDXW +: IDXW]]) ||
                        (cand_src_b[i*IDXW +: IDXW] != '0 && vis_pend[cand_src_b[i*IDXW +: IDXW]]))); // R2

    if (i > 0) begin : g_order
      AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (issue_ok[i] && cand_valid[i-1]) |-> issue_ok[i-1]); // R6
    end
  end
endmodule

bind issue_scoreboard sb_checker #(.LANES(LANES), .NREGS(NREGS), .IDXW(IDXW)) u_sb_checker (
  .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_src_a(cand_src_a),
  .cand_src_b(cand_src_b), .issue_ok(issue_ok), .set_mask(set_mask),
  .clr_mask(clr_mask), .vis_pend(vis_pend), .pending_flags(pending_flags));

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;
  import sb_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] v = '0, w = '0, wbe = '0;
  logic [5:0] sa = '0, sb = '0, d = '0, wi = '0;
  logic [1:0] ok_e, ok_l;
  logic [7:0] pf_e, pf_l;
  logic [7:0] m_e = '0, m_l = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  issue_scoreboard #(.LANES(2), .WB_PORTS(2), .NREGS(8), .CLR_ORDER(CLR_BEFORE_SEARCH)) i_issue_scoreboard (
    .clk(clk), .rst(rst), .cand_valid(v), .cand_src_a(sa), .cand_src_b(sb),
    .cand_dst(d), .cand_wen(w), .issue_ok(ok_e), .wb_en(wbe), .wb_idx(wi),
    .pending_flags(pf_e));

  issue_scoreboard #(.LANES(2), .WB_PORTS(2), .NREGS(8), .CLR_ORDER(CLR_AFTER_SEARCH)) i_issue_scoreboard_late (
    .clk(clk), .rst(rst), .cand_valid(v), .cand_src_a(sa), .cand_src_b(sb),
    .cand_dst(d), .cand_wen(w), .issue_ok(ok_l), .wb_en(wbe), .wb_idx(wi),
    .pending_flags(pf_l));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit busy(input logic [7:0] t, input logic [2:0] r);
    return (r != 3'd0) && t[r];
  endfunction

  // model of issue decisions for two lanes, visible table t
  function automatic logic [1:0] model_issue(input logic [7:0] t);
    bit h0, h1, w0live;
    h0 = busy(t, sa[2:0]) || busy(t, sb[2:0]) || (w[0] && busy(t, d[2:0]));
    w0live = v[0] && w[0] && (d[2:0] != 3'd0);
    h1 = busy(t, sa[5:3]) || busy(t, sb[5:3]) || (w[1] && busy(t, d[5:3])) ||
         (w0live && (sa[5:3] == d[2:0] || sb[5:3] == d[2:0] || (w[1] && d[5:3] == d[2:0])));
    return {v[1] && !h1 && !(v[0] && h0), v[0] && !h0};
  endfunction

  function automatic logic [7:0] clr_bits();
    logic [7:0] c;
    c = '0;
    if (wbe[0]) c[wi[2:0]] = 1'b1;
    if (wbe[1]) c[wi[5:3]] = 1'b1;
    c[0] = 1'b0;
    return c;
  endfunction

  function automatic logic [7:0] advance(input logic [7:0] m, input logic [1:0] iss);
    logic [7:0] n;
    n = m & ~clr_bits();
    if (iss[0] && w[0]) n[d[2:0]] = 1'b1;
    if (iss[1] && w[1]) n[d[5:3]] = 1'b1;
    n[0] = 1'b0;
    return n;
  endfunction

  // drive on falling edge, check issue before rising edge, check flags after it
  task automatic step(input string tag, input logic [1:0] iv, input logic [1:0] iw,
                      input logic [5:0] isa, input logic [5:0] isb, input logic [5:0] id,
                      input logic [1:0] iwbe, input logic [5:0] iwi);
    logic [1:0] xe, xl;
    @(negedge clk);
    v = iv; w = iw; sa = isa; sb = isb; d = id; wbe = iwbe; wi = iwi;
    #1;
    xe = model_issue(m_e & ~clr_bits());
    xl = model_issue(m_l);
    chk({tag, " issue early"}, {6'd0, ok_e}, {6'd0, xe});
    chk({tag, " issue late"},  {6'd0, ok_l}, {6'd0, xl});
    m_e = advance(m_e, xe);
    m_l = advance(m_l, xl);
    @(posedge clk);
    #1;
    chk({tag, " flags early"}, pf_e, m_e);
    chk({tag, " flags late"},  pf_l, m_l);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; v = '0; wbe = '0;
    repeat (2) @(posedge clk);
    #1;
    m_e = '0; m_l = '0;
    chk("R1 reset early", pf_e, 8'h00);
    chk("R1 reset late",  pf_l, 8'h00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // lane0 writes r3, lane1 reads r3: lane1 held (R3)
    step("R3", 2'b11, 2'b01, {3'd3, 3'd1}, {3'd0, 3'd2}, {3'd0, 3'd3}, 2'b00, 6'd0);
    chk("R8 r3 set", {7'd0, pf_e[3]}, 8'd1);
    // lane0 reads pending r3 (R2), younger lane free but held (R6)
    step("R2", 2'b11, 2'b00, {3'd0, 3'd3}, 6'd0, 6'd0, 2'b00, 6'd0);
    // lane0 writes pending r3 (R5)
    step("R5", 2'b01, 2'b01, 6'd0, 6'd0, {3'd0, 3'd3}, 2'b00, 6'd0);
    // both lanes write r4: lane1 held (R4)
    step("R4", 2'b11, 2'b11, 6'd0, 6'd0, {3'd4, 3'd4}, 2'b00, 6'd0);
    // register zero everywhere (R7)
    step("R7", 2'b11, 2'b11, 6'd0, 6'd0, 6'd0, 2'b11, 6'd0);
    chk("R7 zero idle", {7'd0, pf_e[0]}, 8'd0);
    // writeback clears r3 (R9)
    step("R9", 2'b00, 2'b00, 6'd0, 6'd0, 6'd0, 2'b01, {3'd0, 3'd3});
    chk("R9 r3 cleared", {7'd0, pf_l[3]}, 8'd0);
    // read r4 while it is being cleared: orderings differ (R11)
    step("R11", 2'b01, 2'b00, {3'd0, 3'd4}, 6'd0, 6'd0, 2'b10, {3'd4, 3'd0});
    chk("R11 early issues", {6'd0, ok_e}, 8'd1);
    // insert r5 while clearing r5 (R10)
    step("R10", 2'b01, 2'b01, 6'd0, 6'd0, {3'd0, 3'd5}, 2'b01, {3'd0, 3'd5});
    chk("R10 set wins", {7'd0, pf_e[5]}, 8'd1);
    // invalid lane0 does not hold lane1 (R6)
    step("R6", 2'b10, 2'b11, {3'd2, 3'd5}, 6'd0, {3'd6, 3'd5}, 2'b00, 6'd0);
    // broad sweep
    for (int n = 0; n < 4000; n++) begin
      step("R6 R8 sweep", 2'($urandom), 2'($urandom), 6'($urandom), 6'($urandom),
           6'($urandom), 2'($urandom), 6'($urandom));
      if (n == 2000) do_reset();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule